// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit executes the vector configuration instructions. Each request brings a requested application vector length (AVL), a flag saying the AVL source register is x0, and a new type word. The type word comes from an immediate or from a register; the decode stage has already chosen between them. The unit decodes the type word and checks that the machine supports it. It derives the largest element count that one instruction can cover, then grants a vector length. In the same cycle it returns the granted length, which goes to the destination register. On the next clock edge it commits the type, length and maximum-length state.

The vector register width `VLEN`, the widest element `ELEN`, the scalar width `XLEN` and the largest register-grouping code `MAX_GRP` are parameters. The unit accepts a request in every cycle that `req_valid` is high and never applies back-pressure, so it has no ready signal. A caller may issue requests back to back. The state outputs always show the last accepted setting.

Top module: `vcfg_unit`

## Requirements
- R1: The type word is decoded as follows. Bit 0 selects the representation: 0 means integer, 1 means floating point. Bits 3:1 hold the element-width code, bits 5:4 hold the grouping code, and bits XLEN-1:6 are reserved. After an accepted request, `vtype_q` holds the requested word unchanged.
- R2: The element width is SEW = 8 << code, covering 8 to 1024 bits. The maximum count is VLMAX = (VLEN/SEW) << grouping code. After an accepted request it appears on `vlmax_q`.
- R3: When AVL <= VLMAX, the granted length equals AVL.
- R4: When AVL >= 2*VLMAX, the granted length equals VLMAX.
- R5: When VLMAX < AVL < 2*VLMAX, the granted length is ceil(AVL/2).
- R6: When `req_avl_is_x0` is high, `req_avl` is ignored and VLMAX is used as the AVL, so the grant equals VLMAX.
- R7: `resp_illegal` goes high in the request cycle if the type word is unsupported. A word is unsupported if SEW > ELEN, if any reserved bit is 1, or if the grouping code exceeds `MAX_GRP`.
- R8: An unsupported request leaves `vl_q`, `vlmax_q` and `vtype_q` unchanged. During that request, `resp_vl` shows the current `vl_q`.
- R9: `resp_vl` is combinational and valid in the request cycle. The state registers load on the next rising edge and keep their value in any cycle without a request.
- R10: After reset, `vl_q` = 0, `vtype_q` = 0 and `vlmax_q` = VLEN/8.
- R11: An AVL of 0 grants 0 and a positive AVL grants a positive length. The grant never exceeds the AVL or VLMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A configuration request is present this cycle |
| req_avl | input | XLEN | Requested application vector length |
| req_avl_is_x0 | input | 1 | AVL source is x0: use VLMAX instead of `req_avl` |
| req_type | input | XLEN | New type word |
| resp_vl | output | XLEN | Granted length for the destination register (same cycle) |
| resp_illegal | output | 1 | Unsupported type word: raise an illegal-instruction exception |
| vl_q | output | XLEN | Committed vector length |
| vlmax_q | output | XLEN | Committed maximum element count |
| vtype_q | output | XLEN | Committed type word |

## Verification
Two functions can fall in the same cycle. One is the combinational grant on `resp_vl` for a new request. The other is the commit of the previous request's state. The bench provokes this overlap by issuing requests back to back, including a legal request followed at once by an illegal one. In that case the illegal request's `resp_vl` must already show the length that was just committed. The scoreboard captures each response before the clock edge and the state after it. It judges both against an independent model that updates only on legal settings.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;
  // Field positions inside the type word
  localparam int REP_BIT  = 0;
  localparam int SEW_LO   = 1;
  localparam int SEW_W    = 3;
  localparam int GRP_LO   = 4;
  localparam int GRP_W    = 2;
  localparam int RSV_LO   = 6;
  localparam int SEW_CODES = 1 << SEW_W;
  localparam int MIN_SEW  = 8;

  typedef struct packed {
    logic [GRP_W-1:0] grp;
    logic [SEW_W-1:0] sew_code;
    logic             is_fp;
  } vtype_fields_t;
endpackage

// File: rtl/vcfg_type_decode.sv
module vcfg_type_decode
  import vcfg_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter int ELEN    = 64,
  parameter int XLEN    = 32,
  parameter int MAX_GRP = 2
) (
  input  logic [XLEN-1:0] type_word,
  output logic            legal,
  output logic [XLEN-1:0] vlmax
);
  localparam int VLEN_BYTES = VLEN / MIN_SEW;

  vtype_fields_t         fld;
  logic [SEW_CODES-1:0]  sew_supported;
  logic                  sew_ok, rsv_ok, grp_ok;

  assign fld = vtype_fields_t'(type_word[RSV_LO-1:0]);

  // One supported flag per element-width code, fixed by ELEN
  for (genvar gi = 0; gi < SEW_CODES; gi++) begin : g_sew
    if ((MIN_SEW << gi) <= ELEN) begin : g_yes
      assign sew_supported[gi] = 1'b1;
    end else begin : g_no
      assign sew_supported[gi] = 1'b0;
    end
  end

  assign sew_ok = sew_supported[fld.sew_code];
  assign rsv_ok = ~|type_word[XLEN-1:RSV_LO];
  assign grp_ok = (int'(fld.grp) <= MAX_GRP);
  assign legal  = sew_ok & rsv_ok & grp_ok;

  // VLEN/SEW * 2^grp, computed as bytes-per-register scaled by shifts
  assign vlmax = (XLEN'(VLEN_BYTES) << fld.grp) >> fld.sew_code;
endmodule

// File: rtl/vcfg_len_grant.sv
module vcfg_len_grant #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] avl,
  input  logic            avl_is_x0,
  input  logic [XLEN-1:0] vlmax,
  output logic [XLEN-1:0] vl
);
  logic [XLEN-1:0] avl_eff;
  logic [XLEN:0]   twice_max;
  logic [XLEN-1:0] half_up;

  assign avl_eff   = avl_is_x0 ? vlmax : avl;
  assign twice_max = {vlmax, 1'b0};
  assign half_up   = (avl_eff >> 1) + {{(XLEN-1){1'b0}}, avl_eff[0]};

  always_comb begin
    if (avl_eff <= vlmax) begin
      vl = avl_eff;
    end else if ({1'b0, avl_eff} >= twice_max) begin
      vl = vlmax;
    end else begin
      vl = half_up;
    end
  end
endmodule

// File: rtl/vcfg_state.sv
module vcfg_state #(
  parameter int VLEN = 128,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [XLEN-1:0] vl_d,
  input  logic [XLEN-1:0] vlmax_d,
  input  logic [XLEN-1:0] vtype_d,
  output logic [XLEN-1:0] vl_q,
  output logic [XLEN-1:0] vlmax_q,
  output logic [XLEN-1:0] vtype_q
);
  localparam logic [XLEN-1:0] RST_VLMAX = XLEN'(VLEN / 8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vl_q    <= '0;
      vlmax_q <= RST_VLMAX;
      vtype_q <= '0;
    end else if (load) begin
      vl_q    <= vl_d;
      vlmax_q <= vlmax_d;
      vtype_q <= vtype_d;
    end
  end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
  parameter int VLEN    = 128,
  parameter int ELEN    = 64,
  parameter int XLEN    = 32,
  parameter int MAX_GRP = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [XLEN-1:0] req_avl,
  input  logic            req_avl_is_x0,
  input  logic [XLEN-1:0] req_type,
  output logic [XLEN-1:0] resp_vl,
  output logic            resp_illegal,
  output logic [XLEN-1:0] vl_q,
  output logic [XLEN-1:0] vlmax_q,
  output logic [XLEN-1:0] vtype_q
);
  logic            type_legal;
  logic [XLEN-1:0] new_vlmax;
  logic [XLEN-1:0] new_vl;

  vcfg_type_decode #(
    .VLEN(VLEN), .ELEN(ELEN), .XLEN(XLEN), .MAX_GRP(MAX_GRP)
  ) u_dec (
    .type_word(req_type),
    .legal    (type_legal),
    .vlmax    (new_vlmax)
  );

  vcfg_len_grant #(.XLEN(XLEN)) u_grant (
    .avl      (req_avl),
    .avl_is_x0(req_avl_is_x0),
    .vlmax    (new_vlmax),
    .vl       (new_vl)
  );

  vcfg_state #(.VLEN(VLEN), .XLEN(XLEN)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (req_valid & type_legal),
    .vl_d   (new_vl),
    .vlmax_d(new_vlmax),
    .vtype_d(req_type),
    .vl_q   (vl_q),
    .vlmax_q(vlmax_q),
    .vtype_q(vtype_q)
  );

  assign resp_vl      = type_legal ? new_vl : vl_q;
  assign resp_illegal = req_valid & ~type_legal;
endmodule

// File: rtl/vcfg_unit_chk.sv
module vcfg_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [XLEN-1:0] req_avl,
  input logic            req_avl_is_x0,
  input logic [XLEN-1:0] req_type,
  input logic [XLEN-1:0] resp_vl,
  input logic            resp_illegal,
  input logic [XLEN-1:0] vl_q,
  input logic [XLEN-1:0] vlmax_q,
  input logic [XLEN-1:0] vtype_q
);
  assert_vtype_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !resp_illegal) |=> (vtype_q == $past(req_type)));

  assert_reserved_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vtype_q[XLEN-1:6] == '0));

  assert_hold_on_illegal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && resp_illegal) |=>
      ($stable(vl_q) && $stable(vlmax_q) && $stable(vtype_q)));

  assert_vl_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !resp_illegal) |=> (vl_q == $past(resp_vl)));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(vl_q) && $stable(vlmax_q) && $stable(vtype_q)));

  assert_zero_avl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !resp_illegal && !req_avl_is_x0 && req_avl == '0) |-> (resp_vl == '0));

  assert_grant_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !resp_illegal && !req_avl_is_x0 && req_avl != '0) |->
      (resp_vl != '0 && resp_vl <= req_avl));

  assert_state_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vl_q <= vlmax_q));
endmodule

bind vcfg_unit vcfg_unit_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/vcfg_unit_test.sv
`timescale 1ns/1ps
module vcfg_unit_test;
  localparam int VLEN = 128, ELEN = 64, XLEN = 32, MAX_GRP = 2;

  typedef struct {
    logic [XLEN-1:0] rvl;
    logic            ill;
    logic [XLEN-1:0] vl;
    logic [XLEN-1:0] vlmax;
    logic [XLEN-1:0] vtype;
    string           tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_avl_is_x0 = 1'b0;
  logic [XLEN-1:0] req_avl = '0, req_type = '0;
  logic [XLEN-1:0] resp_vl, vl_q, vlmax_q, vtype_q;
  logic resp_illegal;

  int total = 0, bad = 0;
  bit finished = 0;
  exp_t sb[$];
  logic [XLEN-1:0] m_vl, m_vlmax, m_vtype;

  always #2.5 clk = ~clk;

  vcfg_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_avl(req_avl),
    .req_avl_is_x0(req_avl_is_x0), .req_type(req_type), .resp_vl(resp_vl),
    .resp_illegal(resp_illegal), .vl_q(vl_q), .vlmax_q(vlmax_q), .vtype_q(vtype_q)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Driver: computes the expected result from the requirements, queues it, drives one cycle
  task automatic do_req(input logic [XLEN-1:0] avl, input bit x0,
                        input logic [XLEN-1:0] tw, input string tag);
    exp_t e;
    int code, grp, sew;
    bit legal;
    logic [XLEN-1:0] vm, a, g;
    code  = int'(tw[3:1]);
    grp   = int'(tw[5:4]);
    sew   = 8 << code;
    legal = (sew <= ELEN) && (tw[XLEN-1:6] == '0) && (grp <= MAX_GRP);
    vm    = XLEN'((VLEN / sew) * (1 << grp));
    a     = x0 ? vm : avl;
    if (a <= vm) g = a;
    else if (a >= 2 * vm) g = vm;
    else g = (a + 1) / 2;
    e.ill = !legal;
    if (legal) begin
      m_vl = g; m_vlmax = vm; m_vtype = tw;
    end
    e.rvl = m_vl; e.vl = m_vl; e.vlmax = m_vlmax; e.vtype = m_vtype; e.tag = tag;
    sb.push_back(e);
    req_valid = 1'b1; req_avl = avl; req_avl_is_x0 = x0; req_type = tw;
    @(posedge clk); #1;
    req_valid = 1'b0; req_avl_is_x0 = 1'b0;
  endtask

  // Monitor: response captured before the edge, state after it
  initial begin
    forever begin
      @(negedge clk);
      if (req_valid) begin
        logic [XLEN-1:0] cap_vl;
        logic cap_ill;
        exp_t e;
        cap_vl  = resp_vl;
        cap_ill = resp_illegal;
        @(posedge clk); #2;
        if (sb.size() == 0) begin
          chk(1'b0, "R9", "unexpected response", cap_vl, '0);
        end else begin
          e = sb.pop_front();
          chk(cap_ill == e.ill, e.tag, "resp_illegal", XLEN'(cap_ill), XLEN'(e.ill));
          chk(cap_vl == e.rvl, e.tag, "resp_vl", cap_vl, e.rvl);
          chk(vl_q == e.vl, e.tag, "vl_q", vl_q, e.vl);
          chk(vlmax_q == e.vlmax, e.tag, "vlmax_q", vlmax_q, e.vlmax);
          chk(vtype_q == e.vtype, e.tag, "vtype_q", vtype_q, e.vtype);
        end
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      chk(1'b0, "watchdog", "timeout", '0, '0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_vl = '0; m_vlmax = XLEN'(VLEN / 8); m_vtype = '0;
    #12 rst_n = 1'b1;
    @(posedge clk); #1;
    // R10: reset state
    chk(vl_q == '0, "R10", "vl_q", vl_q, '0);
    chk(vlmax_q == 16, "R10", "vlmax_q", vlmax_q, 16);
    chk(vtype_q == '0, "R10", "vtype_q", vtype_q, '0);

    // SEW32 integer, no grouping: VLMAX 4
    do_req(3,   0, 32'h4, "R3");
    do_req(4,   0, 32'h4, "R3");
    do_req(5,   0, 32'h4, "R5");
    do_req(7,   0, 32'h4, "R5");
    do_req(8,   0, 32'h4, "R4");
    do_req(100, 0, 32'h4, "R4");
    // x0 source with SEW8 and grouping x4: VLMAX 64; req_avl ignored
    do_req(5,   1, 32'h20, "R6");
    // floating point SEW16: VLMAX 8, AVL 0
    do_req(0,   0, 32'h3, "R11");
    do_req(1,   0, 32'h3, "R11");
    // SEW64 grouping x2: VLMAX 4
    do_req(6,   0, 32'h16, "R2");
    do_req(9,   0, 32'h16, "R2");
    // legal then illegal back to back: SEW above ELEN
    do_req(2,   0, 32'h1, "R1");
    do_req(2,   0, 32'h8, "R7");
    // reserved bit set
    do_req(3,   0, 32'h44, "R8");
    // grouping code beyond MAX_GRP
    do_req(3,   0, 32'h30, "R8");
    // top SEW code illegal with x0
    do_req(0,   1, 32'hE, "R7");
    // R9: idle cycles keep the state
    repeat (5) @(posedge clk);
    #2;
    chk(vl_q == m_vl, "R9", "idle vl_q", vl_q, m_vl);
    chk(vtype_q == m_vtype, "R9", "idle vtype_q", vtype_q, m_vtype);
    chk(sb.size() == 0, "R9", "queue drained", XLEN'(sb.size()), '0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule